// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The host presents one word-sized read or write at a time through a valid/ready handshake. The controller turns each request into a sequence of registered strobes on the memory side: an active-low select, an active-high select, an active-low write enable and an active-low output enable. It also drives write data with its own tri-state enable. Read data comes back with a one-cycle valid pulse.

Every timing window is a parameter counted in clock cycles, and each is raised to at least one cycle. Writes are gated by output enable. The RAM's output enable is released first, and the controller waits for the RAM's output drivers to turn off before it drives the bus. A sleep input parks the RAM in its low-power retention state by pulling the active-high select low. When sleep is removed, a recovery count must elapse before the host sees ready again.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset, `mem_cs1_n`, `mem_we_n`, `mem_oe_n` and `mem_cs2` are high, `mem_dq_oe` and `rd_valid` are low, and `req_ready` is high while `sleep` is low.
- R2: `req_ready` is high only when the controller is idle and `sleep` is low. It is low during every access, every inter-access gap, retention and recovery.
- R3: A read accepted at edge k holds `mem_cs1_n` and `mem_oe_n` low and `mem_we_n` high for exactly AA_CYC cycles after edge k. `mem_addr` equals the request address and stays unchanged throughout.
- R4: At the edge that ends the read window, the controller captures `mem_dq_in`. `rd_data` shows that value and `rd_valid` is high for exactly the next cycle.
- R5: A write accepted at edge k keeps `mem_oe_n` high and holds `mem_cs1_n` low with drivers off for REL_CYC cycles. Drivers turn on in the same edge that `mem_we_n` falls.
- R6: `mem_we_n` stays low for max(WP_CYC, DW_CYC, SEL_CYC - REL_CYC) cycles. During that time `mem_dq_oe` is high and `mem_dq_out` equals the request data.
- R7: When `mem_we_n` rises, `mem_cs1_n` is still low and the drivers are still on. One cycle later, `mem_cs1_n` rises and `mem_dq_oe` falls together.
- R8: After each access, all strobes stay inactive for max(GAP_CYC, 1) cycles before the next access can be accepted.
- R9: When `sleep` is high in idle, `mem_cs2` goes low from the next cycle on, with the other strobes inactive. Requests presented meanwhile start no access and change no memory word.
- R10: When `sleep` falls, `mem_cs2` returns high and `req_ready` stays low for exactly REC_CYC cycles.
- R11: A `sleep` that rises during an access does not cut it short. Retention begins only after the access and its gap, so `mem_cs2` is never low while `mem_cs1_n` is low.
- R12: `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Hold RAM in retention |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 17 | RAM address |
| mem_cs1_n | output | 1 | Active-low select |
| mem_cs2 | output | 1 | Active-high select, low = retention |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven to RAM |
| mem_dq_oe | output | 1 | Enable for data drivers |
| mem_dq_in | input | 8 | Data returned from RAM |

## Verification
The bench builds the block with AA_CYC=3, REL_CYC=2, WP_CYC=2, DW_CYC=3, SEL_CYC=4, GAP_CYC=1 and REC_CYC=6. With these values, the data-setup term, rather than the pulse-width term, sets the write pulse length. The recovery window is also short enough that its exact length can be counted at the ports. The default recovery of over a million cycles cannot be reached within the run, so its length is checked only through the small override.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_WR_REL,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_GAP,
        ST_SLEEP,
        ST_RECOVER
    } phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 17,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned AA_CYC  = 18,
    parameter int unsigned REL_CYC = 7,
    parameter int unsigned WP_CYC  = 13,
    parameter int unsigned DW_CYC  = 8,
    parameter int unsigned SEL_CYC = 15,
    parameter int unsigned GAP_CYC = 1,
    parameter int unsigned REC_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned AA_EFF    = max_u(AA_CYC, 1);
    localparam int unsigned REL_EFF   = max_u(REL_CYC, 1);
    localparam int unsigned SEL_REST  = (SEL_CYC > REL_EFF) ? (SEL_CYC - REL_EFF) : 1;
    localparam int unsigned PULSE_EFF = max_u(max_u(WP_CYC, DW_CYC), SEL_REST);
    localparam int unsigned GAP_EFF   = max_u(GAP_CYC, 1);
    localparam int unsigned REC_EFF   = max_u(REC_CYC, 1);
    localparam int unsigned LONGEST   = max_u(max_u(max_u(AA_EFF, REL_EFF), max_u(PULSE_EFF, GAP_EFF)), REC_EFF);
    localparam int unsigned CNT_W     = $clog2(LONGEST + 1);

    typedef struct packed {
        phase_e            state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dq;
        logic              cs1_n;
        logic              cs2;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap_now;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_now  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (sleep) begin
                    ctl_d.state = ST_SLEEP;
                    ctl_d.cs2   = 1'b0;
                end else if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.cs1_n = 1'b0;
                    tmr_load    = 1'b1;
                    if (req_write) begin
                        ctl_d.state = ST_WR_REL;
                        ctl_d.dq    = req_wdata;
                        tmr_val     = CNT_W'(REL_EFF - 1);
                    end else begin
                        ctl_d.state = ST_RD_WAIT;
                        ctl_d.oe_n  = 1'b0;
                        tmr_val     = CNT_W'(AA_EFF - 1);
                    end
                end
            end
            ST_RD_WAIT: begin
                if (tmr_done) begin
                    cap_now     = 1'b1;
                    ctl_d.cs1_n = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.state = ST_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(GAP_EFF - 1);
                end
            end
            ST_WR_REL: begin
                if (tmr_done) begin
                    ctl_d.dq_oe = 1'b1;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.state = ST_WR_PULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(PULSE_EFF - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    ctl_d.we_n  = 1'b1;
                    ctl_d.state = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                ctl_d.dq_oe = 1'b0;
                ctl_d.cs1_n = 1'b1;
                ctl_d.state = ST_GAP;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(GAP_EFF - 1);
            end
            ST_GAP: begin
                if (tmr_done) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_SLEEP: begin
                if (!sleep) begin
                    ctl_d.cs2   = 1'b1;
                    ctl_d.state = ST_RECOVER;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(REC_EFF - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_done) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.addr  <= '0;
            ctl_q.dq    <= '0;
            ctl_q.cs1_n <= 1'b1;
            ctl_q.cs2   <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.dq_oe <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_now),
        .din     (mem_dq_in),
        .dout    (rd_data),
        .valid   (rd_valid)
    );

    assign req_ready  = (ctl_q.state == ST_IDLE) && !sleep;
    assign mem_addr   = ctl_q.addr;
    assign mem_cs1_n  = ctl_q.cs1_n;
    assign mem_cs2    = ctl_q.cs2;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.dq;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R12

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && mem_we_n && mem_oe_n && mem_cs2 && !mem_dq_oe)); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr)); // R3

    AST_WE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_dq_oe)); // R6

    AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !mem_we_n); // R5

    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs1_n)); // R7

    AST_RETAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs2 |-> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R11
endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_access_ctrl_test.sv
module sram_access_ctrl_test;
    localparam int P_AA    = 3;
    localparam int P_REL   = 2;
    localparam int P_WP    = 2;
    localparam int P_DW    = 3;
    localparam int P_SEL   = 4;
    localparam int P_GAP   = 1;
    localparam int P_REC   = 6;
    localparam int P_PULSE = (P_WP > P_DW) ? ((P_WP > P_SEL - P_REL) ? P_WP : P_SEL - P_REL)
                                           : ((P_DW > P_SEL - P_REL) ? P_DW : P_SEL - P_REL);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [16:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #2 clk = ~clk;

    sram_access_ctrl #(
        .AA_CYC(P_AA), .REL_CYC(P_REL), .WP_CYC(P_WP), .DW_CYC(P_DW),
        .SEL_CYC(P_SEL), .GAP_CYC(P_GAP), .REC_CYC(P_REC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // behavioural RAM: drives only when selected, reading and output-enabled
    logic [7:0] dev_mem [0:255];
    logic [7:0] ref_mem [0:255];
    wire dev_drive = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
    assign mem_dq_in = dev_drive ? dev_mem[mem_addr[7:0]] : 8'hEE;

    typedef struct packed {
        logic        cs1_n, cs2, we_n, oe_n, dq_oe, ready, rdv;
        logic [16:0] addr;
        logic [7:0]  dq;
        logic [7:0]  rdat;
    } exp_t;

    exp_t sched[$];
    exp_t cur;
    bit   sleeping = 0;
    bit   cur_idle = 1;
    bit   finished = 0;
    logic prev_we_n = 1'b1;
    int   checks = 0;
    int   failures = 0;

    function automatic exp_t mk(logic c1, logic c2, logic we, logic oe, logic de,
                                logic rdy, logic rv, logic [16:0] a, logic [7:0] d,
                                logic [7:0] r);
        exp_t e;
        e.cs1_n = c1; e.cs2 = c2; e.we_n = we; e.oe_n = oe; e.dq_oe = de;
        e.ready = rdy; e.rdv = rv; e.addr = a; e.dq = d; e.rdat = r;
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(req_ready == cur.ready, "R2 ready", req_ready, cur.ready);
        chk(mem_oe_n == cur.oe_n, "R3 oe_n", mem_oe_n, cur.oe_n);
        chk(mem_cs1_n == cur.cs1_n, "R8 cs1_n", mem_cs1_n, cur.cs1_n);
        chk(mem_we_n == cur.we_n, "R6 we_n", mem_we_n, cur.we_n);
        chk(mem_cs2 == cur.cs2, "R9 cs2", mem_cs2, cur.cs2);
        chk(mem_dq_oe == cur.dq_oe, "R5 dq_oe", mem_dq_oe, cur.dq_oe);
        chk(rd_valid == cur.rdv, "R4 rd_valid", rd_valid, cur.rdv);
        if (!cur.cs1_n) chk(mem_addr == cur.addr, "R3 addr", mem_addr, cur.addr);
        if (cur.dq_oe)  chk(mem_dq_out == cur.dq, "R6 dq_out", mem_dq_out, cur.dq);
        if (cur.rdv)    chk(rd_data == cur.rdat, "R4 rd_data", rd_data, cur.rdat);
        chk(!(mem_dq_oe && !mem_oe_n), "R12 contention", mem_oe_n, 1);
        chk(!(!mem_cs2 && !mem_cs1_n), "R11 retention during access", mem_cs2, 1);
        if (!prev_we_n && mem_we_n) begin
            chk(mem_dq_oe && !mem_cs1_n, "R7 hold at write end", {mem_dq_oe, mem_cs1_n}, 2'b10);
            dev_mem[mem_addr[7:0]] = mem_dq_out;
        end
        prev_we_n = mem_we_n;
    endtask

    task automatic advance();
        if (sched.size() > 0) begin
            cur = sched.pop_front();
            cur_idle = 0;
        end else if (sleeping) begin
            if (!sleep) begin
                sleeping = 0;
                repeat (P_REC) sched.push_back(mk(1, 1, 1, 1, 0, 0, 0, 0, 0, 0));
                cur = sched.pop_front();
            end else begin
                cur = mk(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
            end
            cur_idle = 0;
        end else if (!cur_idle) begin
            cur = mk(1, 1, 1, 1, 0, !sleep, 0, 0, 0, 0);
            cur_idle = 1;
        end else if (sleep) begin
            sleeping = 1;
            cur = mk(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
            cur_idle = 0;
        end else if (req_valid) begin
            if (req_write) begin
                ref_mem[req_addr[7:0]] = req_wdata;
                repeat (P_REL)   sched.push_back(mk(0, 1, 1, 1, 0, 0, 0, req_addr, 0, 0));
                repeat (P_PULSE) sched.push_back(mk(0, 1, 0, 1, 1, 0, 0, req_addr, req_wdata, 0));
                sched.push_back(mk(0, 1, 1, 1, 1, 0, 0, req_addr, req_wdata, 0));
                repeat (P_GAP)   sched.push_back(mk(1, 1, 1, 1, 0, 0, 0, 0, 0, 0));
            end else begin
                repeat (P_AA) sched.push_back(mk(0, 1, 1, 0, 0, 0, 0, req_addr, 0, 0));
                sched.push_back(mk(1, 1, 1, 1, 0, 0, 1, 0, 0, ref_mem[req_addr[7:0]]));
                repeat (P_GAP - 1) sched.push_back(mk(1, 1, 1, 1, 0, 0, 0, 0, 0, 0));
            end
            cur = sched.pop_front();
            cur_idle = 0;
        end else begin
            cur = mk(1, 1, 1, 1, 0, 1, 0, 0, 0, 0);
        end
    endtask

    task automatic step(input logic s, input logic v, input logic w,
                        input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        compare();
        sleep = s; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        advance();
    endtask

    task automatic settle(input logic s);
        for (int g = 0; g < 200; g++) begin
            if (sched.size() == 0 && cur_idle && !sleeping) break;
            step(s, 0, 0, 0, 0);
        end
    endtask

    task automatic access(input logic w, input logic [16:0] a, input logic [7:0] d);
        step(0, 1, w, a, d);
        settle(0);
    endtask

    int rec_cnt;

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'(i) ^ 8'hA5;
            ref_mem[i] = 8'(i) ^ 8'hA5;
        end
        cur = mk(1, 1, 1, 1, 0, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet strobes straight out of reset
        chk(mem_cs1_n && mem_we_n && mem_oe_n && mem_cs2 && !mem_dq_oe && !rd_valid && req_ready,
            "R1 reset state", {mem_cs1_n, mem_we_n, mem_oe_n, mem_cs2, mem_dq_oe, rd_valid, req_ready},
            7'b1111001);
        step(0, 0, 0, 0, 0);
        // R3 R4: plain reads of preset words
        access(0, 17'h00010, 0);
        access(0, 17'h1_00F3, 0);
        // R5 R6 R7: write then read back, back to back across the gap (R8)
        access(1, 17'h1_0033, 8'h3C);
        access(0, 17'h1_0033, 0);
        access(1, 17'h00034, 8'hFF);
        access(1, 17'h00035, 8'h00);
        access(0, 17'h00034, 0);
        access(0, 17'h00035, 0);
        // R9: sleep in idle with a write request presented that must be dropped
        for (int i = 0; i < 6; i++) step(1, 1, 1, 17'h00077, 8'h99);
        // R10: count not-ready cycles after release
        step(0, 0, 0, 0, 0);
        rec_cnt = 0;
        for (int g = 0; g < 50; g++) begin
            step(0, 0, 0, 0, 0);
            if (req_ready) break;
            rec_cnt++;
        end
        chk(rec_cnt == P_REC, "R10 recovery length", rec_cnt, P_REC);
        settle(0);
        access(0, 17'h00077, 0);
        // R11: sleep rises just after a write is accepted
        step(0, 1, 1, 17'h00044, 8'h12);
        for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        settle(0);
        access(0, 17'h00044, 0);
        // mixed patterns
        for (int i = 0; i < 8; i++) begin
            access(1, 17'(16'h0100 + i * 9), 8'(i * 37 + 5));
            access(0, 17'(16'h0100 + i * 9), 0);
        end
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule